// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer, 9 bits wide, whose write side and read side run on separate, unrelated clocks. Besides full and empty it drives two early-warning outputs, almost-empty and almost-full. Each warning trips at a threshold held in a small bank of offset registers. All four status outputs are active low, and each is registered in the clock domain of the side that acts on it.

The offset registers are not memory-mapped. Software reaches them through the FIFO's own data ports, with the shared `fifo_sel` pin pulled low. In that mode a write on the write clock lands in the next offset register of a fixed four-step rotation. A read on the read clock returns the next register of the same rotation, and the read side keeps its own position pointer.

When `fifo_sel` is high, the ports move ordinary FIFO data. The depth is a parameter: a power of two, 256 by default, and never below 256.

Top module: `pflag_fifo`

## Requirements
- R1: With `fifo_sel`=1, a write-clock edge with `wr_en`=1 and `full_n`=1 stores `wdata`. A read-clock edge with `rd_en`=1 and `empty_n`=1 presents the oldest stored word on `rdata` after that same edge. Words come out in the order they were written.
- R2: A write-clock edge with `wr_en`=0 changes neither the FIFO nor any offset register, whatever the level of `fifo_sel`.
- R3: A write-clock edge with `wr_en`=1 and `fifo_sel`=0 loads an offset register and adds nothing to the FIFO.
- R4: Offset loads step through a fixed rotation, then wrap back to position 0:
  - position 0: empty-threshold low byte, loaded from `wdata[7:0]`;
  - position 1: empty-threshold high part, loaded from `wdata[AW-9:0]`;
  - position 2: full-threshold low byte;
  - position 3: full-threshold high part.
  Bit 8 of a low-byte load is dropped. With DEPTH=256 there is no high part, so positions 1 and 3 always read 0.
- R5: Reset (synchronous, active high, held across edges of both clocks) sets the following:
  - both low bytes to 7 and both high parts to 0;
  - both rotation pointers to position 0;
  - `rdata` to 0;
  - `empty_n`=0, `almost_empty_n`=0, `full_n`=1, `almost_full_n`=1.
- R6: A read-clock edge with `rd_en`=1 and `fifo_sel`=0 puts the register at the read-side rotation position on `rdata` after that edge. The read-side position then advances in the R4 order. A low byte reads back as {0, byte} and a high part reads back zero-extended. No FIFO word is consumed.
- R7: Let n be the empty threshold {high part, low byte}. `almost_empty_n` is low when the unread count is at most n and high when it is n+1 or more. It is updated on the read clock.
- R8: Let m be the full threshold. `almost_full_n` is low when the unread count is at least DEPTH−m and high otherwise. It is updated on the write clock.
- R9: `full_n` is low exactly when DEPTH words are unread. A FIFO write while full is ignored.
- R10: `empty_n` is low exactly when no word is unread. A FIFO read while empty is ignored, and `rdata` holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Synchronous active-high reset, seen by both clock domains |
| wclk | input | 1 | Write-side clock |
| wr_en | input | 1 | Write enable |
| fifo_sel | input | 1 | 1: ports carry FIFO data; 0: ports reach the offset registers |
| wdata | input | 9 | Write data or offset value |
| rclk | input | 1 | Read-side clock |
| rd_en | input | 1 | Read enable |
| rdata | output | 9 | Read data or offset readback |
| empty_n | output | 1 | Low when the FIFO holds no word (read clock) |
| almost_empty_n | output | 1 | Low when at most n words are unread (read clock) |
| almost_full_n | output | 1 | Low when at least DEPTH−m words are unread (write clock) |
| full_n | output | 1 | Low when the FIFO holds DEPTH words (write clock) |

## Verification
The hardest states to reach from the ports are the exact threshold edges on a full buffer. The thresholds are count DEPTH−m, count DEPTH, and the write that arrives one past full. Random traffic passes through them only rarely, and never with the pointers in a known phase.

The stimulus therefore first loads known thresholds through the rotation. It then fills the buffer one word at a time and lets both synchronizers settle before sampling the flags at each boundary count. After that it drains the buffer and attempts a read while empty.

Random rounds follow, each with fresh thresholds and a write/read bias that pushes the buffer toward full or toward empty. The bench checks every read against a model queue and compares all four flags with the model's count once traffic stops.

// File: rtl/pflag_fifo_pkg.sv
package pflag_fifo_pkg;

  // Rotation order of the offset registers; the order is behaviour.
  typedef enum logic [1:0] {
    SEL_EMPTY_LO = 2'd0,
    SEL_EMPTY_HI = 2'd1,
    SEL_FULL_LO  = 2'd2,
    SEL_FULL_HI  = 2'd3
  } ofs_sel_e;

  localparam int unsigned LO_W = 8;
  localparam logic [LO_W-1:0] OFS_DEFAULT = 8'd7;

endpackage

// File: rtl/pflag_fifo_sync.sv
module pflag_fifo_sync #(
  parameter int unsigned W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/pflag_fifo_ram.sv
module pflag_fifo_ram #(
  parameter int unsigned DW = 9,
  parameter int unsigned AW = 8
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pflag_fifo_offsets.sv
module pflag_fifo_offsets
  import pflag_fifo_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 9
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ld_we,
  input  logic [LO_W-1:0] ld_data,
  input  ofs_sel_e        rb_sel,
  output logic [AW-1:0]   empty_thr,
  output logic [AW-1:0]   full_thr,
  output logic [DW-1:0]   rb_data
);
  localparam int unsigned HI_W = (AW > LO_W) ? AW - LO_W : 1;

  ofs_sel_e        wsel;
  logic [LO_W-1:0] e_lo, f_lo;
  logic [HI_W-1:0] e_hi, f_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      wsel <= SEL_EMPTY_LO;
      e_lo <= OFS_DEFAULT;
      f_lo <= OFS_DEFAULT;
    end else if (ld_we) begin
      if (wsel == SEL_EMPTY_LO) e_lo <= ld_data;
      if (wsel == SEL_FULL_LO)  f_lo <= ld_data;
      wsel <= ofs_sel_e'(wsel + 2'd1);
    end
  end

  generate
    if (AW > LO_W) begin : g_hi
      always_ff @(posedge clk) begin
        if (rst) begin
          e_hi <= '0;
          f_hi <= '0;
        end else if (ld_we) begin
          if (wsel == SEL_EMPTY_HI) e_hi <= ld_data[HI_W-1:0];
          if (wsel == SEL_FULL_HI)  f_hi <= ld_data[HI_W-1:0];
        end
      end
      assign empty_thr = {e_hi, e_lo};
      assign full_thr  = {f_hi, f_lo};
    end else begin : g_no_hi
      assign e_hi      = '0;
      assign f_hi      = '0;
      assign empty_thr = e_lo;
      assign full_thr  = f_lo;
    end
  endgenerate

  always_comb begin
    case (rb_sel)
      SEL_EMPTY_LO: rb_data = DW'(e_lo);
      SEL_EMPTY_HI: rb_data = DW'(e_hi);
      SEL_FULL_LO:  rb_data = DW'(f_lo);
      default:      rb_data = DW'(f_hi);
    endcase
  end
endmodule

// File: rtl/pflag_fifo.sv
module pflag_fifo
  import pflag_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned DW    = 9
) (
  input  logic          rst,
  input  logic          wclk,
  input  logic          wr_en,
  input  logic          fifo_sel,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rd_en,
  output logic [DW-1:0] rdata,
  output logic          empty_n,
  output logic          almost_empty_n,
  output logic          almost_full_n,
  output logic          full_n
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = AW + 1;

  function automatic logic [PW-1:0] bin2gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // ---------------- write domain ----------------
  logic [PW-1:0] wbin, wgray, wbin_nx, wcnt_nx, rgray_w, rbin_w;
  logic          wr_go, ld_we;
  logic [AW-1:0] empty_thr, full_thr;

  assign wr_go   = wr_en & fifo_sel & full_n;
  assign ld_we   = wr_en & ~fifo_sel;
  assign rbin_w  = gray2bin(rgray_w);
  assign wbin_nx = wbin + PW'(wr_go);
  assign wcnt_nx = wbin_nx - rbin_w;

  always_ff @(posedge wclk) begin
    if (rst) begin
      wbin          <= '0;
      wgray         <= '0;
      full_n        <= 1'b1;
      almost_full_n <= 1'b1;
    end else begin
      wbin          <= wbin_nx;
      wgray         <= bin2gray(wbin_nx);
      full_n        <= (wcnt_nx != PW'(DEPTH));
      almost_full_n <= (({1'b0, wcnt_nx} + (PW+1)'(full_thr)) < (PW+1)'(DEPTH));
    end
  end

  // ---------------- read domain ----------------
  logic [PW-1:0] rbin, rgray, rbin_nx, rcnt_nx, wgray_r, wbin_r;
  logic          rd_go, rb_go, src_ofs;
  logic [DW-1:0] ram_q, ofs_q, rb_data;
  ofs_sel_e      rsel;

  assign rd_go   = rd_en & fifo_sel & empty_n;
  assign rb_go   = rd_en & ~fifo_sel;
  assign wbin_r  = gray2bin(wgray_r);
  assign rbin_nx = rbin + PW'(rd_go);
  assign rcnt_nx = wbin_r - rbin_nx;

  always_ff @(posedge rclk) begin
    if (rst) begin
      rbin           <= '0;
      rgray          <= '0;
      empty_n        <= 1'b0;
      almost_empty_n <= 1'b0;
      rsel           <= SEL_EMPTY_LO;
      ofs_q          <= '0;
      src_ofs        <= 1'b1;
    end else begin
      rbin           <= rbin_nx;
      rgray          <= bin2gray(rbin_nx);
      empty_n        <= (rcnt_nx != '0);
      almost_empty_n <= (rcnt_nx > {1'b0, empty_thr});
      if (rb_go) begin
        ofs_q   <= rb_data;
        rsel    <= ofs_sel_e'(rsel + 2'd1);
        src_ofs <= 1'b1;
      end else if (rd_go) begin
        src_ofs <= 1'b0;
      end
    end
  end

  assign rdata = src_ofs ? ofs_q : ram_q;

  // ---------------- submodules ----------------
  pflag_fifo_sync #(.W(PW)) u_sync_r2w (
    .clk(wclk), .rst(rst), .d(rgray), .q(rgray_w)
  );

  pflag_fifo_sync #(.W(PW)) u_sync_w2r (
    .clk(rclk), .rst(rst), .d(wgray), .q(wgray_r)
  );

  pflag_fifo_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk(wclk), .we(wr_go), .waddr(wbin[AW-1:0]), .wdata(wdata),
    .rclk(rclk), .re(rd_go), .raddr(rbin[AW-1:0]), .rdata(ram_q)
  );

  pflag_fifo_offsets #(.AW(AW), .DW(DW)) u_ofs (
    .clk(wclk), .rst(rst), .ld_we(ld_we), .ld_data(wdata[LO_W-1:0]),
    .rb_sel(rsel), .empty_thr(empty_thr), .full_thr(full_thr),
    .rb_data(rb_data)
  );
endmodule

// File: rtl/pflag_fifo_chk.sv
module pflag_fifo_chk #(
  parameter int unsigned PW = 9,
  parameter int unsigned DW = 9
) (
  input logic          rst,
  input logic          wclk,
  input logic          rclk,
  input logic          wr_en,
  input logic          rd_en,
  input logic          fifo_sel,
  input logic          full_n,
  input logic          empty_n,
  input logic          almost_full_n,
  input logic          almost_empty_n,
  input logic [DW-1:0] rdata,
  input logic [PW-1:0] wbin,
  input logic [PW-1:0] rbin
);
  // R9: a FIFO write while full leaves the write pointer alone
  a_r9_no_overflow: assert property (@(posedge wclk) disable iff (rst)
    (wr_en && fifo_sel && !full_n) |=> $stable(wbin));

  // R9 with R8: full always lies inside the almost-full region
  a_r9_full_in_af: assert property (@(posedge wclk) disable iff (rst)
    !full_n |-> !almost_full_n);

  // R2: an idle write edge does not move the write pointer
  a_r2_idle_write: assert property (@(posedge wclk) disable iff (rst)
    !wr_en |=> $stable(wbin));

  // R3: an offset load does not enter the FIFO
  a_r3_load_no_fifo: assert property (@(posedge wclk) disable iff (rst)
    (wr_en && !fifo_sel) |=> $stable(wbin));

  // R10: a read while empty moves nothing and keeps rdata
  a_r10_no_underflow: assert property (@(posedge rclk) disable iff (rst)
    (rd_en && fifo_sel && !empty_n) |=> ($stable(rbin) && $stable(rdata)));

  // R10 with R7: empty always lies inside the almost-empty region
  a_r10_empty_in_ae: assert property (@(posedge rclk) disable iff (rst)
    !empty_n |-> !almost_empty_n);

  // R6: readback of an offset register consumes no FIFO word
  a_r6_readback_no_consume: assert property (@(posedge rclk) disable iff (rst)
    (rd_en && !fifo_sel) |=> $stable(rbin));
endmodule

bind pflag_fifo pflag_fifo_chk #(.PW(PW), .DW(DW)) u_chk (
  .rst(rst), .wclk(wclk), .rclk(rclk), .wr_en(wr_en), .rd_en(rd_en),
  .fifo_sel(fifo_sel), .full_n(full_n), .empty_n(empty_n),
  .almost_full_n(almost_full_n), .almost_empty_n(almost_empty_n),
  .rdata(rdata), .wbin(wbin), .rbin(rbin)
);

// File: tb/tb_pflag_fifo.sv
`timescale 1ns/1ps
module tb_pflag_fifo;
  localparam int DEPTH = 256;
  localparam int DW    = 9;

  logic          rst = 1'b1;
  logic          wclk = 1'b0, rclk = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0, fifo_sel = 1'b1;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          empty_n, almost_empty_n, almost_full_n, full_n;

  always #4    wclk = ~wclk;   // 125 MHz
  always #5.5  rclk = ~rclk;

  pflag_fifo #(.DEPTH(DEPTH), .DW(DW)) dut (
    .rst(rst), .wclk(wclk), .wr_en(wr_en), .fifo_sel(fifo_sel), .wdata(wdata),
    .rclk(rclk), .rd_en(rd_en), .rdata(rdata), .empty_n(empty_n),
    .almost_empty_n(almost_empty_n), .almost_full_n(almost_full_n),
    .full_n(full_n)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [DW-1:0] q[$];
  logic [DW-1:0] exp_rd = '0;
  int ofs_m[4] = '{7, 0, 7, 0};
  int wsel_m = 0, rsel_m = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_ae(input int cnt);
    return (cnt > ofs_m[0]) ? 1 : 0;
  endfunction
  function automatic int exp_af(input int cnt);
    return (cnt >= DEPTH - ofs_m[2]) ? 0 : 1;
  endfunction

  task automatic wr_op(input bit en, input bit sel, input logic [DW-1:0] d);
    bit acc;
    @(negedge wclk);
    wr_en = en; fifo_sel = sel; wdata = d;
    acc = en && sel && full_n;
    @(posedge wclk); #1;
    wr_en = 1'b0;
    if (acc) q.push_back(d);
    else if (en && !sel) begin
      ofs_m[wsel_m] = (wsel_m % 2 == 1) ? 0 : int'(d[7:0]);
      wsel_m = (wsel_m + 1) % 4;
    end
  endtask

  task automatic rd_op(input bit en, input bit sel);
    bit acc;
    @(negedge rclk);
    rd_en = en; fifo_sel = sel;
    acc = en && sel && empty_n;
    @(posedge rclk); #2;
    rd_en = 1'b0;
    if (acc) begin
      exp_rd = q.pop_front();
      chk("R1 fifo order", int'(rdata), int'(exp_rd));
    end else if (en && !sel) begin
      exp_rd = DW'(ofs_m[rsel_m]);
      chk("R6 offset readback", int'(rdata), int'(exp_rd));
      rsel_m = (rsel_m + 1) % 4;
    end else if (en) begin
      chk("R10 rdata held on empty read", int'(rdata), int'(exp_rd));
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge wclk);
    repeat (8) @(negedge rclk);
  endtask

  task automatic check_flags(input string tag);
    int c;
    c = q.size();
    @(negedge wclk);
    chk({"R9 full_n ", tag}, int'(full_n), (c == DEPTH) ? 0 : 1);
    chk({"R8 almost_full_n ", tag}, int'(almost_full_n), exp_af(c));
    @(negedge rclk);
    chk({"R10 empty_n ", tag}, int'(empty_n), (c == 0) ? 0 : 1);
    chk({"R7 almost_empty_n ", tag}, int'(almost_empty_n), exp_ae(c));
  endtask

  task automatic load_offsets(input int e_lo, input int f_lo);
    wr_op(1, 0, DW'(e_lo));
    wr_op(1, 0, 9'h1FF);   // high part: absent at this depth
    wr_op(1, 0, DW'(f_lo));
    wr_op(1, 0, 9'h1FF);
  endtask

  initial begin
    repeat (150000) @(posedge wclk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (6) @(posedge wclk);
    repeat (6) @(posedge rclk);
    @(negedge wclk); rst = 1'b0;
    settle();

    // R5: reset state
    chk("R5 rdata after reset", int'(rdata), 0);
    chk("R5 empty_n", int'(empty_n), 0);
    chk("R5 almost_empty_n", int'(almost_empty_n), 0);
    chk("R5 full_n", int'(full_n), 1);
    chk("R5 almost_full_n", int'(almost_full_n), 1);
    // R5 defaults through the R6 readback rotation (7,0,7,0)
    repeat (4) rd_op(1, 0);

    // R4 / R3: load n=5, m=10; bit 8 of low bytes is dropped
    wr_op(1, 0, 9'h105);
    wr_op(1, 0, 9'h1FF);
    wr_op(1, 0, 9'h00A);
    wr_op(1, 0, 9'h0FF);
    repeat (4) rd_op(1, 0);   // R4 expects 5,0,10,0
    settle();
    check_flags("R3 after loads");

    // R2: idle edges under both select levels change nothing
    repeat (3) wr_op(0, 0, 9'h033);
    repeat (3) wr_op(0, 1, 9'h044);
    settle();
    check_flags("R2 idle");
    repeat (4) rd_op(1, 0);

    // Directed fill with threshold edges (R7, R8, R9)
    for (int i = 0; i < DEPTH; i++) begin
      wr_op(1, 1, DW'(i * 7 + 3));
      if (q.size() == 5 || q.size() == 6 || q.size() == 245 ||
          q.size() == 246 || q.size() == 255 || q.size() == 256) begin
        settle();
        check_flags($sformatf("count %0d", q.size()));
      end
    end
    wr_op(1, 1, 9'h1EE);        // R9: extra write while full
    settle();
    check_flags("R9 after overfill");
    rd_op(1, 0);                // R6 readback while full consumes nothing
    settle();
    check_flags("R6 no consume");
    while (q.size() > 0) rd_op(1, 1);
    settle();
    check_flags("drained");
    rd_op(1, 1);                // R10 read while empty
    rd_op(1, 1);
    // Re-align readback pointer to position 0
    while (rsel_m != 0) rd_op(1, 0);

    // Random rounds with fresh thresholds and varied bias
    for (int r = 0; r < 6; r++) begin
      int pw, pr;
      pw = (r % 3 == 0) ? 85 : (r % 3 == 1) ? 30 : 60;
      pr = (r % 3 == 0) ? 30 : (r % 3 == 1) ? 85 : 60;
      load_offsets($urandom_range(0, 60), $urandom_range(0, 60));
      repeat (4) rd_op(1, 0);
      fork
        for (int k = 0; k < 700; k++)
          wr_op($urandom_range(0, 99) < pw, 1, DW'($urandom));
        for (int k = 0; k < 500; k++)
          rd_op($urandom_range(0, 99) < pr, 1);
      join
      settle();
      check_flags($sformatf("random round %0d", r));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule